// File: doc/BRIEF.md
# Fractional-Rate Two-Output PWM Channel

This block is a single pulse-width modulation channel. A 16-bit counter advances on ticks from a fractional clock divider. The divisor has 8 integer bits and 4 fraction bits, so the tick rate can be set in sixteenths of a clock period. The counter runs from zero to a programmable limit. In sawtooth mode it then restarts at zero. In phase-correct mode it turns around and counts back down.

Two outputs, A and B, compare the counter against their own thresholds. Each output can be inverted on its own. While the channel runs, software can shift the counter by one count in either direction. A one-clock wrap pulse is provided for an interrupt collector outside the block. All settings pass through a small synchronous write port and a combinational read port.

Top module: `pwm_slice`

## Requirements
- R1: After reset, the control word reads 0, the divisor reads 0x010 (1.0), the counter reads 0, the thresholds read 0 and the limit reads 0xFFFF.
- R2: Addresses:
  - 0 is control. Bit 0 is run, bit 1 is phase-correct, bit 2 inverts A, bit 3 inverts B, bits 5:4 are the divider mode, bit 6 is a retard request and bit 7 is an advance request.
  - 1 is the divisor: integer part in bits 11:4, fraction in bits 3:0.
  - 2 is the counter.
  - 3 holds threshold A in bits 15:0 and threshold B in bits 31:16.
  - 4 is the limit.
  - Bits 7:6 of control and every unused address read as 0.
- R3: With divisor D = 16*integer + fraction, the k-th clock since run was set yields a count tick exactly when floor(16k/D) exceeds floor(16(k-1)/D). An integer part of 0 counts as 256.
- R4: In sawtooth mode each tick adds one to the counter, and a tick at the limit sets it to 0.
- R5: In phase-correct mode the counter climbs to the limit, then steps down to 0, then climbs again. It never exceeds a nonzero limit that it started below.
- R6: Output A is (counter < threshold A) XOR invert-A, and output B is (counter < threshold B) XOR invert-B.
- R7: With run clear, the counter holds its value and the divider phase restarts from zero.
- R8: A counter write takes effect at once and overrides any tick in the same cycle.
- R9: An advance request written with run set makes the next tick move the counter two steps. The request then clears itself.
- R10: A retard request written with run set makes the next tick leave the counter unchanged. The request then clears itself. Both requests in one write cancel each other, and requests written with run clear are dropped.
- R11: The wrap pulse is high for one clock after a tick that takes the counter from the limit to 0 in sawtooth mode, or from 1 down to 0 in phase-correct mode.
- R12: The divider mode field is stored and read back but does not change the tick rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |
| wrap_pulse | output | 1 | One-clock wrap indication |

## Verification
A wrong counter value or a wrong count direction shows up first at out_a and out_b. The duty edge moves at the next threshold crossing, which comes within one counter period. A divider phase error moves every edge of both outputs and the wrap pulse by one or more clocks, starting at the next tick. Because the bench model predicts both outputs and the wrap pulse for every clock, such an error is reported in the cycle it first becomes visible. Counter reads expose a skipped or extra step from a phase request right after the next tick.

// File: rtl/pwm_slice.sv
module pwm_slice #(
  parameter int CW = 16,
  parameter int IW = 8,
  parameter int FW = 4,
  parameter int AW = 3
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [2*CW-1:0] wdata,
  output logic [2*CW-1:0] rdata,
  output logic            out_a,
  output logic            out_b,
  output logic            wrap_pulse
);
  localparam int DW   = IW + FW;
  localparam int AccW = DW + 1;
  localparam int RW   = 2 * CW;

  typedef struct packed {
    logic          w;
    logic          up;
    logic [CW-1:0] c;
  } st_t;

  logic            en_q, pc_q, inv_a_q, inv_b_q, up_q, adv_p, ret_p, wrap_q;
  logic [1:0]      mode_q;
  logic [DW-1:0]   div_q;
  logic [CW-1:0]   ctr_q, cmp_a_q, cmp_b_q, top_q;
  logic [AccW-1:0] acc_q, acc_sum, div_eff;
  logic            tick, step_go;
  logic            wr_ctl, wr_div, wr_ctr, wr_cmp, wr_top;
  st_t             s1, s2, nxt;

  assign wr_ctl = wr_en && addr == AW'(0);
  assign wr_div = wr_en && addr == AW'(1);
  assign wr_ctr = wr_en && addr == AW'(2);
  assign wr_cmp = wr_en && addr == AW'(3);
  assign wr_top = wr_en && addr == AW'(4);

  assign div_eff = {~|div_q[DW-1:FW], div_q};
  assign acc_sum = acc_q + AccW'(2 ** FW);
  assign tick    = en_q && (acc_sum >= div_eff);
  assign step_go = tick && !ret_p && !wr_ctr;

  function automatic st_t step(input logic [CW-1:0] c, input logic up,
                               input logic pc, input logic [CW-1:0] top);
    st_t s;
    s.w  = 1'b0;
    s.up = up;
    s.c  = c;
    if (!pc) begin
      if (c == top) begin
        s.c = '0;
        s.w = 1'b1;
      end else s.c = c + 1'b1;
    end else if (up) begin
      if (c >= top) begin
        s.up = 1'b0;
        s.c  = (c == '0) ? c : c - 1'b1;
      end else s.c = c + 1'b1;
    end else if (c == '0) begin
      s.up = 1'b1;
      s.c  = c + 1'b1;
    end else begin
      s.c = c - 1'b1;
      s.w = (c == CW'(1));
    end
    return s;
  endfunction

  always_comb begin
    s1 = step(ctr_q, up_q, pc_q, top_q);
    s2 = step(s1.c, s1.up, pc_q, top_q);
    if (adv_p) begin
      nxt.w  = s1.w | s2.w;
      nxt.up = s2.up;
      nxt.c  = s2.c;
    end else nxt = s1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      pc_q    <= 1'b0;
      inv_a_q <= 1'b0;
      inv_b_q <= 1'b0;
      mode_q  <= '0;
      div_q   <= DW'(2 ** FW);
      ctr_q   <= '0;
      cmp_a_q <= '0;
      cmp_b_q <= '0;
      top_q   <= '1;
      up_q    <= 1'b1;
      adv_p   <= 1'b0;
      ret_p   <= 1'b0;
      acc_q   <= '0;
      wrap_q  <= 1'b0;
    end else begin
      acc_q  <= !en_q ? '0 : (tick ? acc_sum - div_eff : acc_sum);
      wrap_q <= step_go && nxt.w;

      if (wr_ctr)       ctr_q <= wdata[CW-1:0];
      else if (step_go) ctr_q <= nxt.c;

      if (!pc_q)        up_q <= 1'b1;
      else if (step_go) up_q <= nxt.up;

      if (wr_ctl) begin
        en_q    <= wdata[0];
        pc_q    <= wdata[1];
        inv_a_q <= wdata[2];
        inv_b_q <= wdata[3];
        mode_q  <= wdata[5:4];
        adv_p   <= wdata[0] & wdata[7] & ~wdata[6];
        ret_p   <= wdata[0] & wdata[6] & ~wdata[7];
      end else if (tick || !en_q) begin
        adv_p <= 1'b0;
        ret_p <= 1'b0;
      end

      if (wr_div) div_q <= wdata[DW-1:0];
      if (wr_cmp) begin
        cmp_a_q <= wdata[CW-1:0];
        cmp_b_q <= wdata[RW-1:CW];
      end
      if (wr_top) top_q <= wdata[CW-1:0];
    end
  end

  always_comb begin
    case (addr)
      AW'(0):  rdata = RW'({mode_q, inv_b_q, inv_a_q, pc_q, en_q});
      AW'(1):  rdata = RW'(div_q);
      AW'(2):  rdata = RW'(ctr_q);
      AW'(3):  rdata = {cmp_b_q, cmp_a_q};
      AW'(4):  rdata = RW'(top_q);
      default: rdata = '0;
    endcase
  end

  assign out_a      = (ctr_q < cmp_a_q) ^ inv_a_q;
  assign out_b      = (ctr_q < cmp_b_q) ^ inv_b_q;
  assign wrap_pulse = wrap_q;
endmodule

// File: rtl/pwm_slice_chk.sv
module pwm_slice_chk #(
  parameter int CW = 16
)(
  input logic          clk,
  input logic          rst_n,
  input logic          en_q,
  input logic          pc_q,
  input logic          tick,
  input logic          adv_p,
  input logic          ret_p,
  input logic          wr_ctr,
  input logic          wr_ctl,
  input logic          wr_top,
  input logic [CW-1:0] ctr,
  input logic [CW-1:0] top,
  input logic          wrap_pulse
);
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q && !wr_ctr |=> $stable(ctr)); // R7

  AST_SAW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !pc_q && !adv_p && !ret_p && !wr_ctr && ctr != top
    |=> ctr == $past(ctr) + 1'b1); // R4

  AST_RETARD_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && ret_p && !wr_ctr |=> $stable(ctr)); // R10

  AST_NUDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_ctl |=> !adv_p && !ret_p); // R9

  AST_PC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q && tick && !wr_ctr && !wr_top && top != '0 && ctr <= top
    |=> ctr <= top); // R5

  AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse && !$past(adv_p) |-> ctr == '0); // R11
endmodule

bind pwm_slice pwm_slice_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .pc_q(pc_q), .tick(tick),
  .adv_p(adv_p), .ret_p(ret_p), .wr_ctr(wr_ctr), .wr_ctl(wr_ctl),
  .wr_top(wr_top), .ctr(ctr_q), .top(top_q), .wrap_pulse(wrap_pulse)
);

// File: tb/sim_pwm_slice.sv
`timescale 1ns/1ps
module sim_pwm_slice;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        out_a, out_b, wrap_pulse;

  always #10 clk = ~clk;

  pwm_slice u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .out_a(out_a), .out_b(out_b), .wrap_pulse(wrap_pulse)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_en, m_pc, m_ia, m_ib, m_up, m_adv, m_ret, m_wrap, m_tk;
  int m_mode, m_div, m_ctr, m_top, m_ca, m_cb, m_k, m_d;

  function automatic int mread(input int a);
    case (a)
      0: return (m_mode << 4) | (int'(m_ib) << 3) | (int'(m_ia) << 2) | (int'(m_pc) << 1) | int'(m_en);
      1: return m_div;
      2: return m_ctr;
      3: return (m_cb << 16) | m_ca;
      4: return m_top;
      default: return 0;
    endcase
  endfunction

  task automatic mstep();
    if (!m_pc) begin
      if (m_ctr == m_top) begin m_ctr = 0; m_wrap = 1; end
      else m_ctr = (m_ctr + 1) & 16'hffff;
    end else if (m_up) begin
      if (m_ctr >= m_top) begin m_up = 0; if (m_ctr != 0) m_ctr--; end
      else m_ctr++;
    end else if (m_ctr == 0) begin
      m_up = 1; m_ctr = 1;
    end else begin
      m_ctr--;
      if (m_ctr == 0) m_wrap = 1;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_pc = 0; m_ia = 0; m_ib = 0; m_mode = 0; m_div = 16;
      m_ctr = 0; m_ca = 0; m_cb = 0; m_top = 16'hffff; m_up = 1;
      m_adv = 0; m_ret = 0; m_wrap = 0; m_k = 0;
    end else begin
      m_d = (((m_div >> 4) == 0) ? 256 : (m_div >> 4)) * 16 + (m_div & 15);
      if (m_en) begin
        m_k++;
        m_tk = ((16 * m_k) / m_d) != ((16 * (m_k - 1)) / m_d);
      end else begin
        m_k = 0;
        m_tk = 0;
      end
      m_wrap = 0;
      if (m_tk && !m_ret && !(wr_en && addr == 2)) begin
        mstep();
        if (m_adv) mstep();
      end
      if (!m_pc) m_up = 1;
      if (wr_en && addr == 0) begin
        m_adv = wdata[0] & wdata[7] & !wdata[6];
        m_ret = wdata[0] & wdata[6] & !wdata[7];
      end else if (m_tk || !m_en) begin
        m_adv = 0; m_ret = 0;
      end
      if (wr_en) case (addr)
        0: begin m_en = wdata[0]; m_pc = wdata[1]; m_ia = wdata[2]; m_ib = wdata[3]; m_mode = int'(wdata[5:4]); end
        1: m_div = int'(wdata[11:0]);
        2: m_ctr = int'(wdata[15:0]);
        3: begin m_ca = int'(wdata[15:0]); m_cb = int'(wdata[31:16]); end
        4: m_top = int'(wdata[15:0]);
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 out_a", 32'(out_a), 32'((m_ctr < m_ca) ^ m_ia));
      chk("R6 out_b", 32'(out_b), 32'((m_ctr < m_cb) ^ m_ib));
      chk("R11 wrap", 32'(wrap_pulse), 32'(m_wrap));
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input string tag);
    @(negedge clk);
    addr = 3'(a);
    #1 chk(tag, rdata, 32'(mread(a)));
  endtask

  task automatic rd_exp(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = 3'(a);
    #1 chk(tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] held;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_exp(0, 32'h0, "R1 ctrl");
    rd_exp(1, 32'h010, "R1 div");
    rd_exp(2, 32'h0, "R1 ctr");
    rd_exp(3, 32'h0, "R1 cmp");
    rd_exp(4, 32'hffff, "R1 top");
    rd_exp(7, 32'h0, "R2 unused addr");

    // sawtooth, divisor 1.0
    wr(4, 9); wr(3, {16'd7, 16'd3}); wr(0, 1);
    idle(40);
    rd(2, "R4 ctr"); rd_exp(3, {16'd7, 16'd3}, "R2 cmp"); rd_exp(4, 9, "R2 top");

    // fractional 2.5 with both inversions
    wr(0, 0); wr(1, 32'h028); wr(0, 32'h0d);
    idle(60);
    rd(2, "R3 frac ctr"); rd_exp(0, 32'h0d, "R2 ctrl");

    // disabled hold
    wr(0, 0); idle(3);
    rd(2, "R7 ctr"); held = rdata;
    idle(20);
    rd_exp(2, held, "R7 hold");

    // integer part zero -> 256
    wr(1, 32'h000); wr(4, 2); wr(3, 1); wr(0, 1);
    idle(800);
    rd(2, "R3 int0 ctr");

    // phase-correct
    wr(0, 0); wr(1, 32'h010); wr(2, 0); wr(4, 5); wr(3, {16'd4, 16'd2}); wr(0, 3);
    idle(60);
    rd(2, "R5 ctr");

    // counter write while running
    wr(2, 3); rd(2, "R8 ctr");
    idle(15); rd(2, "R8 later");

    // phase requests on sawtooth, divisor 4.0
    wr(0, 0); wr(1, 32'h040); wr(4, 20); wr(2, 0); wr(0, 1);
    idle(10);
    wr(0, 32'h81); idle(10);
    rd(2, "R9 advance"); rd_exp(0, 32'h01, "R9 self-clear");
    wr(0, 32'h41); idle(10);
    rd(2, "R10 retard"); rd_exp(0, 32'h01, "R10 self-clear");
    wr(0, 32'hc1); idle(10);
    rd(2, "R10 cancel");
    wr(0, 32'h40); wr(0, 32'h01); idle(10);
    rd(2, "R10 dropped when off");
    wr(0, 32'h83); idle(30);
    rd(2, "R9 advance pc");

    // divider mode field
    wr(0, 32'h31); idle(30);
    rd_exp(0, 32'h31, "R12 mode readback");
    rd(2, "R12 ctr");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule